// File: doc/BRIEF.md
# ECC Write/Read Path with Check-Bit Injection

This block sits between a memory controller's write and read ports and a 72-bit memory word made of 64 data bits and 8 check bits. For each write it builds an 8-bit single-error-correct, double-error-detect check byte over the data. It then XORs that byte with a programmable test mask and presents the 72-bit word to memory one cycle later. Check-byte generation never stops, so memory always holds a consistent code, including while checking is switched off.

For each read it recomputes the check byte from the returned data and forms a syndrome. When checking is on, it corrects single-bit errors, passes multi-bit errors through uncorrected, and emits a one-cycle pulse for each class. The first error is latched into status outputs until software clears them. Software can set mask bits to store chosen check bits inverted. A later read of that word then produces a known syndrome, which exercises the error-handling path without faulty hardware.

Top module: `ecc_inject_path`

## Requirements
- R1: The check byte c is an extended Hamming code. Data bit j sits at the j-th position, counting upward from 3, in the range 1..71 that is not a power of two (bit 0 at position 3, bit 1 at 5, bit 2 at 6, ...). For i in 0..6, c[i] is the XOR of the data bits whose position has bit i set. c[7] makes the XOR of all 64 data bits and c[6:0] even. For example, data 0 gives 0x00 and data 1 gives 0x83. The memory word carries data in bits 63:0 and the check byte in bits 71:64.
- R2: Every written check byte is XORed with the 8-bit test mask. A mask of zero leaves the memory word bit-exact.
- R3: `mem_wr_valid` and `mem_wr_word` follow `wr_valid`/`wr_data` by exactly one clock.
- R4: `rd_out_valid` and the read results follow `rd_valid` by exactly one clock.
- R5: The syndrome is {P, S}. S is the recomputed c[6:0] XOR the stored c[6:0]. P is the XOR of all 72 received bits. With checking on, P=1 marks a single-bit error. The data bit whose position equals S is inverted, if there is one, and `sbe_pulse` is high for one cycle.
- R6: With checking on, P=0 and S≠0 mark a multi-bit error. The raw data is returned and `mbe_pulse` is high for one cycle. The two pulses are never high together.
- R7: With checking off, read data passes through raw, no pulse is raised and status is not touched. Write encoding and masking continue unchanged.
- R8: At the clock edge after an error pulse, if status is empty, it captures the syndrome, the read address and the error type (`sts_multi`=1 for multi-bit). A captured error stays unchanged while later errors occur.
- R9: A clear empties the status. If an error pulse falls in the same cycle as a clear, the new error is captured.
- R10: The register port decodes `reg_addr`: 0 writes the check enable from `reg_wdata[0]`, 1 writes the 8-bit test mask, and 2 issues a clear. After reset, checking is off, the mask is zero, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | 64 | Write data |
| mem_wr_valid | output | 1 | Encoded word valid |
| mem_wr_word | output | 72 | Encoded word {check, data} |
| rd_valid | input | 1 | Read word valid |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_word | input | 72 | Word read from memory |
| rd_out_valid | output | 1 | Read result valid |
| rd_out_data | output | 64 | Corrected or raw read data |
| sbe_pulse | output | 1 | Single-bit error pulse |
| mbe_pulse | output | 1 | Multi-bit error pulse |
| sts_valid | output | 1 | Status holds an error |
| sts_multi | output | 1 | Held error was multi-bit |
| sts_syndrome | output | 8 | Held syndrome {P, S} |
| sts_addr | output | ADDR_W | Held error address |

## Verification
Error capture and a software clear can meet in the same clock. The bench provokes this by issuing the clear exactly in the cycle where an error pulse from a preceding faulty read is high. The case is judged correct only if status comes out holding the new error's address and syndrome. Separately, with status already full, a second error at another address must leave the first record untouched until the clear arrives.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int MAXPOS = WORD_W - 1;

    function automatic logic [CHK_W-1:0] ecc_check(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        int j;
        c = '0;
        j = 0;
        for (int p = 1; p <= MAXPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[j]) c[CHK_W-2:0] = c[CHK_W-2:0] ^ 7'(p);
                j++;
            end
        end
        c[CHK_W-1] = ^d ^ ^c[CHK_W-2:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ecc_fix(input logic [DATA_W-1:0] d,
                                                  input logic [CHK_W-2:0] s);
        logic [DATA_W-1:0] r;
        int j;
        r = d;
        j = 0;
        for (int p = 1; p <= MAXPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (7'(p) == s) r[j] = ~r[j];
                j++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_enc_stage.sv
module ecc_enc_stage
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  mask,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } enc_t;

    enc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.valid = in_valid;
        if (in_valid) st_d.word = {ecc_check(in_data) ^ mask, in_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

    assert_wr_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_word[DATA_W-1:0] == $past(in_data)));
    assert_wr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/ecc_dec_stage.sv
module ecc_dec_stage
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sbe,
    output logic              out_mbe,
    output logic [CHK_W-1:0]  out_syn,
    output logic [ADDR_W-1:0] out_addr
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              mbe;
        logic [CHK_W-1:0]  syn;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    dec_t st_d, st_q;
    logic [DATA_W-1:0] raw_d;
    logic [CHK_W-1:0]  diff_d;
    logic              par_d;

    always_comb begin
        raw_d  = in_word[DATA_W-1:0];
        diff_d = ecc_check(raw_d) ^ in_word[WORD_W-1:DATA_W];
        par_d  = ^diff_d;
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.sbe   = 1'b0;
        st_d.mbe   = 1'b0;
        if (in_valid) begin
            st_d.data = raw_d;
            st_d.addr = in_addr;
            st_d.syn  = {par_d, diff_d[CHK_W-2:0]};
            if (chk_en) begin
                if (par_d) begin
                    st_d.sbe  = 1'b1;
                    st_d.data = ecc_fix(raw_d, diff_d[CHK_W-2:0]);
                end else if (diff_d[CHK_W-2:0] != '0) begin
                    st_d.mbe  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_sbe   = st_q.sbe;
    assign out_mbe   = st_q.mbe;
    assign out_syn   = st_q.syn;
    assign out_addr  = st_q.addr;

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_rd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_sbe && !out_mbe));
    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sbe && out_mbe));
    assert_raw_on_mbe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_en && !(^in_word) && ecc_check(in_word[DATA_W-1:0]) != in_word[WORD_W-1:DATA_W])
        |=> (out_mbe && out_data == $past(in_word[DATA_W-1:0])));
    assert_quiet_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chk_en) |=> (!out_sbe && !out_mbe && out_data == $past(in_word[DATA_W-1:0])));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev_sbe,
    input  logic              ev_mbe,
    input  logic [CHK_W-1:0]  ev_syn,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              sts_valid,
    output logic              sts_multi,
    output logic [CHK_W-1:0]  sts_syn,
    output logic [ADDR_W-1:0] sts_addr
);
    typedef struct packed {
        logic              valid;
        logic              multi;
        logic [CHK_W-1:0]  syn;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.valid = 1'b0;
        if ((ev_sbe || ev_mbe) && !st_d.valid) begin
            st_d.valid = 1'b1;
            st_d.multi = ev_mbe;
            st_d.syn   = ev_syn;
            st_d.addr  = ev_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_valid = st_q.valid;
    assign sts_multi = st_q.multi;
    assign sts_syn   = st_q.syn;
    assign sts_addr  = st_q.addr;

    assert_first_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && !clr) |=> (sts_valid && $stable(sts_addr) && $stable(sts_syn)));
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_valid && (ev_sbe || ev_mbe)) |=> (sts_valid && sts_addr == $past(ev_addr)));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ev_sbe && !ev_mbe) |=> !sts_valid);
endmodule

// File: rtl/ecc_inject_path.sv
module ecc_inject_path
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              wr_valid,
    input  logic [63:0]       wr_data,
    output logic              mem_wr_valid,
    output logic [71:0]       mem_wr_word,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [71:0]       rd_word,
    output logic              rd_out_valid,
    output logic [63:0]       rd_out_data,
    output logic              sbe_pulse,
    output logic              mbe_pulse,
    output logic              sts_valid,
    output logic              sts_multi,
    output logic [7:0]        sts_syndrome,
    output logic [ADDR_W-1:0] sts_addr
);
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CLR  = 2'd2;

    typedef struct packed {
        logic             en;
        logic [CHK_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic clr_w;
    logic [CHK_W-1:0]  syn_w;
    logic [ADDR_W-1:0] ev_addr_w;

    always_comb begin
        cfg_d = cfg_q;
        clr_w = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                SEL_CTRL: cfg_d.en   = reg_wdata[0];
                SEL_MASK: cfg_d.mask = reg_wdata;
                SEL_CLR:  clr_w      = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ecc_enc_stage u_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(wr_valid), .in_data(wr_data), .mask(cfg_q.mask),
        .out_valid(mem_wr_valid), .out_word(mem_wr_word)
    );

    ecc_dec_stage #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .chk_en(cfg_q.en),
        .in_valid(rd_valid), .in_addr(rd_addr), .in_word(rd_word),
        .out_valid(rd_out_valid), .out_data(rd_out_data),
        .out_sbe(sbe_pulse), .out_mbe(mbe_pulse),
        .out_syn(syn_w), .out_addr(ev_addr_w)
    );

    ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr_w),
        .ev_sbe(sbe_pulse), .ev_mbe(mbe_pulse),
        .ev_syn(syn_w), .ev_addr(ev_addr_w),
        .sts_valid(sts_valid), .sts_multi(sts_multi),
        .sts_syn(sts_syndrome), .sts_addr(sts_addr)
    );

    assert_mask_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !(reg_we && reg_addr == SEL_MASK)) |=>
        (mem_wr_word[71:64] == (ecc_check($past(wr_data)) ^ cfg_q.mask)));
endmodule

// File: tb/test_ecc_inject_path.sv
module test_ecc_inject_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        mem_wr_valid;
    logic [71:0] mem_wr_word;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [71:0] rd_word = '0;
    logic        rd_out_valid;
    logic [63:0] rd_out_data;
    logic        sbe_pulse, mbe_pulse, sts_valid, sts_multi;
    logic [7:0]  sts_syndrome;
    logic [31:0] sts_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_inject_path #(.ADDR_W(32)) i_ecc_inject_path (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wr_valid(wr_valid), .wr_data(wr_data), .mem_wr_valid(mem_wr_valid), .mem_wr_word(mem_wr_word),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_word(rd_word),
        .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
        .sbe_pulse(sbe_pulse), .mbe_pulse(mbe_pulse), .sts_valid(sts_valid), .sts_multi(sts_multi),
        .sts_syndrome(sts_syndrome), .sts_addr(sts_addr)
    );

    task automatic chk(input string what, input logic [79:0] act, input logic [79:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic do_write(input logic [63:0] d, output logic [71:0] w);
        wr_valid = 1'b1; wr_data = d;
        step();
        chk("R3 write valid", 80'(mem_wr_valid), 80'd1);
        w = mem_wr_word;
        wr_valid = 1'b0;
        step();
        chk("R3 write valid drop", 80'(mem_wr_valid), 80'd0);
    endtask

    task automatic do_read(input logic [31:0] a, input logic [71:0] w);
        rd_valid = 1'b1; rd_addr = a; rd_word = w;
        step();
        rd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset outputs", 80'({mem_wr_valid, rd_out_valid, sbe_pulse, mbe_pulse, sts_valid}), 80'd0);
        chk("R10 reset word", 80'(mem_wr_word), 80'd0);
    endtask

    task automatic t_encode();
        logic [71:0] w;
        do_write(64'd0, w);
        chk("R1 code of zero", 80'(w), 80'h00_0000000000000000);
        do_write(64'd1, w);
        chk("R1 code of bit0", 80'(w[71:64]), 80'h83);
        do_write(64'd2, w);
        chk("R1 code of bit1", 80'(w[71:64]), 80'h85);
        do_write(64'hDEAD_BEEF_0123_4567, w);
        chk("R2 zero mask data exact", 80'(w[63:0]), 80'hDEAD_BEEF_0123_4567);
    endtask

    task automatic t_inject();
        logic [71:0] w;
        reg_write(2'd1, 8'h01);
        do_write(64'd0, w);
        chk("R2 mask on zero", 80'(w[71:64]), 80'h01);
        reg_write(2'd1, 8'h81);
        do_write(64'd1, w);
        chk("R2 mask on bit0", 80'(w[71:64]), 80'h02);
        reg_write(2'd1, 8'h00);
    endtask

    task automatic t_single();
        logic [71:0] w;
        logic [63:0] d = 64'h0F0F_1234_8765_A5A5;
        reg_write(2'd0, 8'h01);
        do_write(d, w);
        do_read(32'h100, w ^ 72'h1);
        chk("R5 corrected data", 80'(rd_out_data), 80'(d));
        chk("R5 pulses", 80'({rd_out_valid, sbe_pulse, mbe_pulse}), 80'b110);
        step();
        chk("R4 valid one cycle", 80'(rd_out_valid), 80'd0);
        chk("R8 status captured", 80'({sts_valid, sts_multi, sts_syndrome, sts_addr}),
            80'({1'b1, 1'b0, 8'h83, 32'h100}));
    endtask

    task automatic t_hold_multi();
        logic [71:0] w;
        logic [63:0] d = 64'h1111_2222_3333_4444;
        do_write(d, w);
        do_read(32'h200, w ^ 72'h3);
        chk("R6 raw data", 80'(rd_out_data), 80'(d ^ 64'h3));
        chk("R6 pulses", 80'({sbe_pulse, mbe_pulse}), 80'b01);
        step();
        chk("R8 first error held", 80'({sts_valid, sts_multi, sts_syndrome, sts_addr}),
            80'({1'b1, 1'b0, 8'h83, 32'h100}));
    endtask

    task automatic t_clear();
        reg_write(2'd2, 8'h00);
        chk("R9 clear empties", 80'(sts_valid), 80'd0);
    endtask

    task automatic t_same_cycle();
        logic [71:0] w;
        reg_write(2'd1, 8'h03);
        do_write(64'h55, w);
        reg_write(2'd1, 8'h00);
        do_read(32'h300, w);
        chk("R6 injected multi", 80'({sbe_pulse, mbe_pulse}), 80'b01);
        reg_write(2'd2, 8'h00);
        chk("R9 clear with new error", 80'({sts_valid, sts_multi, sts_syndrome, sts_addr}),
            80'({1'b1, 1'b1, 8'h03, 32'h300}));
        reg_write(2'd2, 8'h00);
    endtask

    task automatic t_top_check_bit();
        logic [71:0] w;
        reg_write(2'd1, 8'h80);
        do_write(64'h77, w);
        reg_write(2'd1, 8'h00);
        do_read(32'h400, w);
        chk("R5 top check bit", 80'({rd_out_data, sbe_pulse, mbe_pulse}), 80'({64'h77, 2'b10}));
        step();
        chk("R8 syndrome top bit", 80'(sts_syndrome), 80'h80);
        reg_write(2'd2, 8'h00);
    endtask

    task automatic t_disabled();
        logic [71:0] w;
        reg_write(2'd0, 8'h00);
        do_write(64'd1, w);
        chk("R7 encode while off", 80'(w[71:64]), 80'h83);
        do_read(32'h500, w ^ 72'h1);
        chk("R7 raw and quiet", 80'({rd_out_data, sbe_pulse, mbe_pulse}), 80'({64'd0, 2'b00}));
        step();
        chk("R7 status untouched", 80'(sts_valid), 80'd0);
    endtask

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_encode();
        t_inject();
        t_single();
        t_hold_multi();
        t_clear();
        t_same_cycle();
        t_top_check_bit();
        t_disabled();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule